// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block collects eight interrupt request lines, picks the most urgent one and raises a single interrupt toward the processor. A processor acknowledge made of two low pulses on an active-low line then moves the winner into an in-service set and returns an 8-bit vector. Several copies can be chained. One copy is strapped as master, and up to eight others are strapped as slaves. Each slave's interrupt output drives one request input of the master, so up to 64 sources share one processor interrupt line.

During the first acknowledge pulse the master puts the number of the serviced input on a 3-bit cascade bus. The slave whose programmed identifier equals that number marks its own winner as in service, and it drives the vector during the second pulse. When the master's winner has no slave behind it, the master drives the vector itself and holds the cascade bus at zero. In-service bits are cleared in one of two ways: automatically at the end of the second pulse, or by a non-specific end-of-interrupt command written through a small register port. Each copy has its own chip select and is configured on its own.

Top module: `pic_cascade`

## Requirements
- R1: With `ms_strap` high the unit drives the cascade bus (`cas_oe` high, `cas_o` zero outside an acknowledge). With `ms_strap` low it never drives it.
- R2: `int_o` is high while a latched request is eligible for service, and low otherwise. Requests are sampled one clock after the input changes.
- R3: Input 0 has the highest priority and input 7 the lowest. The vector is the programmed base with bits 2:0 replaced by the winning input's index.
- R4: On the first acknowledge pulse the master sets the in-service bit of its winner. If the cascade map (register 2, one bit per input) marks that input, the master drives the winner's index on `cas_o`; otherwise it keeps `cas_o` at zero.
- R5: A slave sets the in-service bit of its own winner at the end of the first pulse, but only if `cas_i` equals its identifier (register 1 bits 6:4). A slave that is not addressed changes no state and drives nothing for that acknowledge.
- R6: During the second pulse exactly one unit drives `dout`. That unit is the addressed slave, or the master when its winner has no slave attached.
- R7: A request is held back while an in-service bit of equal or higher priority is set.
- R8: A write to register 3 is a non-specific end-of-interrupt command. It clears the highest-priority in-service bit that is set.
- R9: With register 1 bit 0 set (automatic end of interrupt), the unit that took part in the acknowledge clears its in-service bit at the end of the second pulse.
- R10: Register 0 bits 7:3 hold the vector base. A register write takes effect only while `cfg_cs` and `cfg_we` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_strap | input | 1 | Role select: 1 = master, 0 = slave |
| req_i | input | 8 | Request lines, index 0 highest priority |
| int_o | output | 1 | Interrupt request out |
| inta_n | input | 1 | Active-low acknowledge pulses |
| cas_i | input | 3 | Cascade bus in (used by a slave) |
| cas_o | output | 3 | Cascade bus out (driven by a master) |
| cas_oe | output | 1 | Cascade bus output enable |
| dout | output | 8 | Vector byte |
| dout_oe | output | 1 | Vector output enable |
| cfg_cs | input | 1 | Register port select |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |

## Verification
A wrong in-service set shows up at `int_o` within one or two clocks of the change that exposes it. A bit left set after an end-of-interrupt keeps a lower-priority request held back. A bit cleared in error lets a request through early. A wrong winner index, or a wrong decision about which unit drives during the second pulse, shows on the vector byte, on the cascade bus in the first pulse, or as two units driving `dout` at once. The bench builds a master with a slave attached to input 2 and checks these points after every acknowledge and every command.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    ACK_IDLE = 2'd0,
    ACK_P1   = 2'd1,
    ACK_GAP  = 2'd2,
    ACK_P2   = 2'd3
  } ack_st_t;

  localparam logic [1:0] REG_BASE = 2'd0;
  localparam logic [1:0] REG_MODE = 2'd1;
  localparam logic [1:0] REG_MAP  = 2'd2;
  localparam logic [1:0] REG_EOI  = 2'd3;
endpackage

// File: rtl/pic_prio.sv
module pic_prio #(
  parameter int N_IN = 8,
  parameter int ID_W = 3
) (
  input  logic [N_IN-1:0] irr,
  input  logic [N_IN-1:0] isr,
  output logic [N_IN-1:0] elig,
  output logic            any_elig,
  output logic [ID_W-1:0] win_idx
);
  logic [N_IN-1:0] blk;

  // an input is blocked by any in-service bit at its own index or below
  always_comb begin
    blk[0]  = isr[0];
    elig[0] = irr[0] & ~blk[0];
    for (int i = 1; i < N_IN; i++) begin
      blk[i]  = blk[i-1] | isr[i];
      elig[i] = irr[i] & ~blk[i];
    end
  end

  always_comb begin
    win_idx = '0;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (elig[i]) win_idx = ID_W'(i);
    end
  end

  assign any_elig = |elig;
endmodule

// File: rtl/pic_ack_seq.sv
module pic_ack_seq
  import pic_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic inta_n,
  output logic first_ev,
  output logic p1_end_ev,
  output logic done_ev,
  output logic in_p2
);
  ack_st_t st;
  logic    inta_d;
  logic    fall, rise;

  assign fall      = inta_d & ~inta_n;
  assign rise      = ~inta_d & inta_n;
  assign first_ev  = (st == ACK_IDLE) & fall;
  assign p1_end_ev = (st == ACK_P1) & rise;
  assign done_ev   = (st == ACK_P2) & rise;
  assign in_p2     = (st == ACK_P2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ACK_IDLE;
      inta_d <= 1'b1;
    end else begin
      inta_d <= inta_n;
      unique case (st)
        ACK_IDLE: if (fall) st <= ACK_P1;
        ACK_P1:   if (rise) st <= ACK_GAP;
        ACK_GAP:  if (fall) st <= ACK_P2;
        ACK_P2:   if (rise) st <= ACK_IDLE;
        default:  st <= ACK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pic_regs.sv
module pic_regs
  import pic_pkg::*;
#(
  parameter int N_IN = 8,
  parameter int ID_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_cs,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_addr,
  input  logic [N_IN-1:0]      cfg_wdata,
  output logic [N_IN-1:ID_W]   base_hi,
  output logic                 aeoi,
  output logic [ID_W-1:0]      own_id,
  output logic [N_IN-1:0]      cas_map,
  output logic                 eoi_ev
);
  logic wr;
  assign wr     = cfg_cs & cfg_we;
  assign eoi_ev = wr & (cfg_addr == REG_EOI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_hi <= '0;
      aeoi    <= 1'b0;
      own_id  <= '0;
      cas_map <= '0;
    end else if (wr) begin
      case (cfg_addr)
        REG_BASE: base_hi <= cfg_wdata[N_IN-1:ID_W];
        REG_MODE: begin
          aeoi   <= cfg_wdata[0];
          own_id <= cfg_wdata[4 +: ID_W];
        end
        REG_MAP:  cas_map <= cfg_wdata;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/pic_cascade.sv
module pic_cascade #(
  parameter int N_IN = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ms_strap,
  input  logic [N_IN-1:0]          req_i,
  output logic                     int_o,
  input  logic                     inta_n,
  input  logic [$clog2(N_IN)-1:0]  cas_i,
  output logic [$clog2(N_IN)-1:0]  cas_o,
  output logic                     cas_oe,
  output logic [N_IN-1:0]          dout,
  output logic                     dout_oe,
  input  logic                     cfg_cs,
  input  logic                     cfg_we,
  input  logic [1:0]               cfg_addr,
  input  logic [N_IN-1:0]          cfg_wdata
);
  localparam int ID_W = $clog2(N_IN);

  function automatic logic [N_IN-1:0] make_vector(input logic [N_IN-1:ID_W] hi,
                                                  input logic [ID_W-1:0] idx);
    return {hi, idx};
  endfunction

  function automatic logic [N_IN-1:0] lowest_set(input logic [N_IN-1:0] v);
    return v & (~v + N_IN'(1));
  endfunction

  function automatic logic [N_IN-1:0] onehot(input logic [ID_W-1:0] idx);
    return N_IN'(1) << idx;
  endfunction

  logic [N_IN-1:0]    irr, isr, elig, set_m, clr_m;
  logic               any_elig;
  logic [ID_W-1:0]    win_idx, sel_idx, cas_val, own_id;
  logic               sel_valid, slv_hit, mst_own;
  logic               first_ev, p1_end_ev, done_ev, in_p2, eoi_ev, aeoi;
  logic [N_IN-1:0]    cas_map;
  logic [N_IN-1:ID_W] base_hi;
  logic               slv_match;

  pic_regs #(.N_IN(N_IN), .ID_W(ID_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_cs(cfg_cs), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .base_hi(base_hi),
    .aeoi(aeoi), .own_id(own_id), .cas_map(cas_map), .eoi_ev(eoi_ev)
  );

  pic_ack_seq u_seq (
    .clk(clk), .rst_n(rst_n), .inta_n(inta_n), .first_ev(first_ev),
    .p1_end_ev(p1_end_ev), .done_ev(done_ev), .in_p2(in_p2)
  );

  pic_prio #(.N_IN(N_IN), .ID_W(ID_W)) u_prio (
    .irr(irr), .isr(isr), .elig(elig), .any_elig(any_elig), .win_idx(win_idx)
  );

  assign slv_match = ~ms_strap & sel_valid & (cas_i == own_id);

  always_comb begin
    set_m = '0;
    clr_m = '0;
    if (first_ev && ms_strap && any_elig) set_m = onehot(win_idx);
    if (p1_end_ev && slv_match)           set_m = onehot(sel_idx);
    if (done_ev && aeoi && (ms_strap ? sel_valid : slv_hit)) clr_m = onehot(sel_idx);
    if (eoi_ev) clr_m = clr_m | lowest_set(isr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr       <= '0;
      isr       <= '0;
      sel_idx   <= '0;
      sel_valid <= 1'b0;
      slv_hit   <= 1'b0;
      mst_own   <= 1'b0;
      cas_val   <= '0;
    end else begin
      irr <= req_i;
      isr <= (isr | set_m) & ~clr_m;
      if (first_ev) begin
        sel_idx   <= win_idx;
        sel_valid <= any_elig;
        slv_hit   <= 1'b0;
        mst_own   <= ms_strap & any_elig & ~cas_map[win_idx];
        cas_val   <= (ms_strap && any_elig && cas_map[win_idx]) ? win_idx : '0;
      end
      if (p1_end_ev && slv_match) slv_hit <= 1'b1;
      if (done_ev) begin
        sel_valid <= 1'b0;
        slv_hit   <= 1'b0;
        mst_own   <= 1'b0;
        cas_val   <= '0;
      end
    end
  end

  assign int_o   = any_elig;
  assign cas_oe  = ms_strap;
  assign cas_o   = ms_strap ? cas_val : '0;
  assign dout_oe = in_p2 & sel_valid & (ms_strap ? mst_own : slv_hit);
  assign dout    = dout_oe ? make_vector(base_hi, sel_idx) : '0;
endmodule

// File: rtl/pic_cascade_chk.sv
module pic_cascade_chk #(
  parameter int N_IN = 8,
  parameter int ID_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ms_strap,
  input logic            first_ev,
  input logic            p1_end_ev,
  input logic            done_ev,
  input logic            eoi_ev,
  input logic            in_p2,
  input logic            dout_oe,
  input logic            any_elig,
  input logic            aeoi,
  input logic            sel_valid,
  input logic [ID_W-1:0] sel_idx,
  input logic [N_IN-1:0] isr
);
  // R4
  mst_isr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (first_ev && ms_strap && any_elig && !eoi_ev) |=>
      ($countones(isr) == $countones($past(isr)) + 1));

  // R8
  eoi_clear_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_ev && !first_ev && !p1_end_ev && !done_ev && (isr != '0)) |=>
      ($countones(isr) + 1 == $countones($past(isr))));

  // R9
  aeoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ev && aeoi && sel_valid && ms_strap) |=> !isr[sel_idx]);

  // R6
  drive_in_p2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> in_p2);

  // R5
  slv_drive_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ms_strap && dout_oe) |-> (isr != '0));
endmodule

bind pic_cascade pic_cascade_chk #(.N_IN(N_IN), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ms_strap(ms_strap), .first_ev(first_ev),
  .p1_end_ev(p1_end_ev), .done_ev(done_ev), .eoi_ev(eoi_ev), .in_p2(in_p2),
  .dout_oe(dout_oe), .any_elig(any_elig), .aeoi(aeoi), .sel_valid(sel_valid),
  .sel_idx(sel_idx), .isr(isr)
);

// File: tb/sim_pic_cascade.sv
module sim_pic_cascade;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [7:0] mreq = '0, sreq = '0;
  logic       inta_n = 1'b1;
  logic       cs_m = 1'b0, cs_s = 1'b0, we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;

  logic       m_int, s_int, m_cas_oe, s_cas_oe, m_oe, s_oe;
  logic [2:0] m_cas, s_cas;
  logic [7:0] m_dout, s_dout;
  logic [7:0] m_req_w;

  // the slave's interrupt output feeds master input 2
  assign m_req_w = {mreq[7:3], s_int, mreq[1:0]};

  pic_cascade u0 (
    .clk(clk), .rst_n(rst_n), .ms_strap(1'b1), .req_i(m_req_w), .int_o(m_int),
    .inta_n(inta_n), .cas_i(3'd0), .cas_o(m_cas), .cas_oe(m_cas_oe),
    .dout(m_dout), .dout_oe(m_oe), .cfg_cs(cs_m), .cfg_we(we),
    .cfg_addr(addr), .cfg_wdata(wdata)
  );

  pic_cascade u_slv (
    .clk(clk), .rst_n(rst_n), .ms_strap(1'b0), .req_i(sreq), .int_o(s_int),
    .inta_n(inta_n), .cas_i(m_cas), .cas_o(s_cas), .cas_oe(s_cas_oe),
    .dout(s_dout), .dout_oe(s_oe), .cfg_cs(cs_s), .cfg_we(we),
    .cfg_addr(addr), .cfg_wdata(wdata)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  bit seen = 1'b0;
  bit done_flag = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input bit m, input bit s, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_m = m; cs_s = s; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs_m = 1'b0; cs_s = 1'b0; we = 1'b0;
  endtask

  // driver: queue the expected vector, then make the two acknowledge pulses
  task automatic ack(input logic [7:0] exp_vec, input logic [2:0] exp_cas);
    exp_q.push_back(exp_vec);
    @(negedge clk); inta_n = 1'b0;
    @(negedge clk);
    chk("R4 cas bus in first pulse", int'(m_cas), int'(exp_cas));
    @(negedge clk); inta_n = 1'b1;
    @(negedge clk);
    @(negedge clk); inta_n = 1'b0;
    @(negedge clk);
    @(negedge clk); inta_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: compares one vector per second pulse
  always @(negedge clk) begin
    if (rst_n) begin
      if (m_oe && s_oe) begin
        checks++; errors++;
        $display("FAIL R6: both units drive, actual %0h/%0h expected single driver", m_dout, s_dout);
      end
      if ((m_oe || s_oe) && !seen) begin
        seen = 1'b1;
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R6: unexpected vector, actual %0h expected none", m_oe ? m_dout : s_dout);
        end else begin
          chk("R3/R6 vector", int'(m_oe ? m_dout : s_dout), int'(exp_q.pop_front()));
        end
      end else if (!m_oe && !s_oe) begin
        seen = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R2 reset state
    chk("R1 master cas_oe", int'(m_cas_oe), 1);
    chk("R1 slave cas_oe", int'(s_cas_oe), 0);
    chk("R1 master cas idle", int'(m_cas), 0);
    chk("R2 int low after reset", int'(m_int), 0);
    chk("R6 no drive after reset", int'(m_oe | s_oe), 0);

    wr(1, 0, 2'd0, 8'h40);   // R10 master base
    wr(1, 0, 2'd2, 8'h04);   // master: slave on input 2
    wr(0, 1, 2'd0, 8'h88);   // slave base
    wr(0, 1, 2'd1, 8'h20);   // slave id 2, no auto EOI

    // master-only requests
    mreq[5] = 1'b1; settle();
    chk("R2 int on request", int'(m_int), 1);
    ack(8'h45, 3'd0);
    mreq[5] = 1'b0; settle();
    chk("R2 int low when serviced", int'(m_int), 0);
    mreq[6] = 1'b1; settle();
    chk("R7 lower request held back", int'(m_int), 0);
    mreq[3] = 1'b1; settle();
    chk("R7 higher request passes", int'(m_int), 1);
    ack(8'h43, 3'd0);
    mreq[3] = 1'b0;
    wr(1, 0, 2'd3, 8'h00); settle();
    chk("R8 EOI clears highest only", int'(m_int), 0);
    wr(1, 0, 2'd3, 8'h00); settle();
    chk("R8 second EOI releases", int'(m_int), 1);
    ack(8'h46, 3'd0);
    mreq[6] = 1'b0;
    wr(1, 0, 2'd3, 8'h00);

    // R3 simultaneous requests
    mreq[1] = 1'b1; mreq[4] = 1'b1; settle();
    ack(8'h41, 3'd0);
    mreq[1] = 1'b0; settle();
    chk("R7 input 4 blocked by 1", int'(m_int), 0);
    wr(1, 0, 2'd3, 8'h00); settle();
    ack(8'h44, 3'd0);
    mreq[4] = 1'b0;
    wr(1, 0, 2'd3, 8'h00); settle();
    chk("R8 all clear", int'(m_int), 0);

    // cascade through slave on input 2
    sreq[6] = 1'b1; settle();
    chk("R2 slave int", int'(s_int), 1);
    chk("R2 master int from slave", int'(m_int), 1);
    ack(8'h8E, 3'd2);
    settle();
    chk("R5 slave isr set", int'(s_int), 0);
    chk("R4 master isr set", int'(m_int), 0);
    sreq[6] = 1'b0;
    wr(0, 1, 2'd3, 8'h00);
    wr(1, 0, 2'd3, 8'h00); settle();
    chk("R8 cascade cleared", int'(m_int), 0);

    // R9 automatic EOI on the slave
    wr(0, 1, 2'd1, 8'h21);
    sreq[0] = 1'b1; settle();
    ack(8'h88, 3'd2);
    settle();
    chk("R9 slave isr auto cleared", int'(s_int), 1);
    chk("R7 master still holds input 2", int'(m_int), 0);
    sreq[0] = 1'b0;
    wr(1, 0, 2'd3, 8'h00); settle();
    chk("R8 master int low", int'(m_int), 0);

    // R10 write without select is ignored
    @(negedge clk); we = 1'b1; addr = 2'd0; wdata = 8'hF0;
    @(negedge clk); we = 1'b0;

    // R5 slave not addressed keeps its request
    mreq[1] = 1'b1; sreq[3] = 1'b1; settle();
    ack(8'h41, 3'd0);   // R10 base unchanged
    settle();
    chk("R7 slave line blocked at master", int'(m_int), 0);
    chk("R5 unaddressed slave keeps request", int'(s_int), 1);
    mreq[1] = 1'b0;
    wr(1, 0, 2'd3, 8'h00); settle();
    chk("R2 slave request now wins", int'(m_int), 1);
    ack(8'h8B, 3'd2);
    sreq[3] = 1'b0;
    wr(1, 0, 2'd3, 8'h00); settle();
    chk("R9 all idle", int'(m_int | s_int), 0);

    chk("R6 every vector seen", exp_q.size(), 0);
    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule